// File: doc/BRIEF.md
# Serial EEPROM Command Front End

This block is the slave-side command engine of a byte-addressed serial EEPROM. It sits behind four pins: serial clock, active-low select, serial data in and an active-low pause input. It produces one serial data output together with a drive-enable for the tri-state pad. All four pins are brought into a faster system clock through two-flop synchronizers. Edge detectors then turn their transitions into single-cycle events. The block decodes six instructions: set write enable, clear write enable, read status, write status, read array and write array. It keeps the write enable latch. It streams sequential reads from a register-based array through a combinational read port.

Write data is not stored here. Each accepted byte goes to a page-write controller as an address/data load strobe, and a commit strobe follows when select rises on a byte boundary. Before each byte is loaded, the current address is presented to a protection block, which answers with a permit bit. A separate permit bit gates status-register writes.

The control state machine has these states:
- **IDLE**: select is high.
- **OPCODE**: entered on every falling edge of select.
- **ADDR**: collects one or two address bytes.
- **RDDATA** and **RDSTAT**: read phases that shift data out.
- **WRDATA**: loads write bytes.
- **WRSTAT**: takes in the status byte.
- **STATHELD**: holds that byte until select rises.
- **WRENWAIT**: waits for select to rise after a write-enable.
- **DRAIN**: absorbs trailing bits after a write-disable.
- **IGNORE**: entered for invalid or busy-blocked commands.

Transitions are taken on byte completion from OPCODE and ADDR, and from WRSTAT to STATHELD. The rising edge of select returns every state to IDLE.

Top module: `eep_spi_front`

## Requirements
- R1: After reset the drive-enable is low and the write enable latch is clear, so a status read returns bit 1 as 0.
- R2: Opcode 0x06 sets the latch only when select rises after a whole number of bytes. Bytes clocked after it in the same select-low period start no command.
- R3: Opcode 0x04 clears the latch.
- R4: Opcode 0x05 returns the status byte `{stat_hi[5:0], latch, busy}` (bit 1 is the latch, bit 0 is busy). It is sent MSB first and repeats for as long as clocks continue, and it works while busy.
- R5: Opcodes 0000_x011 read the array. For a 512-byte array, x is address bit 8 and one address byte follows. Larger arrays take two address bytes, and smaller ones take one. Sequential bytes follow, and the address wraps from the top address to 0.
- R6: Opcodes 0000_x010 write. With the latch set, each complete data byte whose address the protection block permits produces one load strobe with that address. The low log2(PAGE) address bits then wrap inside the page.
- R7: A data byte at an address the protection block refuses is not loaded.
- R8: A commit strobe is issued when select rises on a byte boundary after at least one load, and the latch then clears.
- R9: Opcode 0x01 followed by one byte issues a status write at the select rise if the latch is set and the status permit is high, and the latch clears. If the permit is low, nothing is written and the latch is kept.
- R10: While busy is high, every opcode except 0x05 is ignored: no output drive, no load, no latch change.
- R11: After an unknown opcode the output stays undriven until the next falling edge of select.
- R12: A pause input sampled low while the serial clock is low releases the output and ignores clocks and input data. Releasing the pause resumes at the same bit.
- R13: If select rises after a bit count that is not a multiple of 8, the command has no commit, status write or latch change.
- R14: Clock modes 0 and 3 both work: input is sampled on the rising edge and output changes on the falling edge. The output is undriven while select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock pin |
| cs_n | input | 1 | Active-low select pin |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause pin |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive-enable for the output pad |
| busy | input | 1 | Internal write cycle in progress |
| stat_hi | input | 6 | Upper six status bits from the protection block |
| rd_addr | output | ADDR_W | Array read address |
| rd_data | input | 8 | Array read data (combinational) |
| prot_addr | output | ADDR_W | Address presented for a write permit |
| prot_ok | input | 1 | Array write permitted at prot_addr |
| sr_ok | input | 1 | Status write permitted |
| pg_load | output | 1 | Load strobe to the page-write controller |
| pg_addr | output | ADDR_W | Address of the loaded byte |
| pg_data | output | 8 | Loaded byte |
| pg_commit | output | 1 | Start of the internal write cycle |
| sr_wr | output | 1 | Status write strobe |
| sr_data | output | 8 | Status byte to write |

## Verification
The bench builds the block with a 9-bit address and 16-byte pages. With this 512-byte size, the address-bit-in-opcode path is exercised, and the wrap from 0x1FF to 0 is reached with a short read. A page boundary is reached at 0x11F with three bytes. A protection boundary at 0x180 lets both permitted and refused addresses be exercised without long transfers. The same build also covers mode 3, a pause in the middle of a byte during a read, and truncated commands.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_RDDATA,
        ST_RDSTAT,
        ST_WRDATA,
        ST_WRSTAT,
        ST_STATHELD,
        ST_WRENWAIT,
        ST_DRAIN,
        ST_IGNORE
    } eep_state_t;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WREN,
        CMD_WRDI,
        CMD_RDSR,
        CMD_WRSR,
        CMD_READ,
        CMD_WRITE
    } eep_cmd_t;

    localparam logic [7:0] OP_SETWE = 8'h06;
    localparam logic [7:0] OP_CLRWE = 8'h04;
    localparam logic [7:0] OP_RDST  = 8'h05;
    localparam logic [7:0] OP_WRST  = 8'h01;
    localparam logic [2:0] OP_RD_LO = 3'b011;
    localparam logic [2:0] OP_WR_LO = 3'b010;

endpackage

// File: rtl/eep_pin_sync.sv
module eep_pin_sync #(
    parameter int          N       = 4,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic meta;
        logic stab;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta <= RST_VAL[g];
                stab <= RST_VAL[g];
            end else begin
                meta <= d[g];
                stab <= meta;
            end
        end
        assign q[g] = stab;
    end
endmodule

// File: rtl/eep_op_decode.sv
module eep_op_decode
    import eep_pkg::*;
#(
    parameter bit A8_IN_OP = 1'b0
) (
    input  logic [7:0] op,
    output eep_cmd_t   cmd
);
    logic low_ok;
    assign low_ok = (op[7:4] == 4'h0) && (A8_IN_OP || !op[3]);

    always_comb begin
        cmd = CMD_NONE;
        if (op == OP_SETWE)                        cmd = CMD_WREN;
        else if (op == OP_CLRWE)                   cmd = CMD_WRDI;
        else if (op == OP_RDST)                    cmd = CMD_RDSR;
        else if (op == OP_WRST)                    cmd = CMD_WRSR;
        else if (low_ok && op[2:0] == OP_RD_LO)    cmd = CMD_READ;
        else if (low_ok && op[2:0] == OP_WR_LO)    cmd = CMD_WRITE;
    end
endmodule

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr #(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step_seq,
    input  logic              step_page,
    output logic [ADDR_W-1:0] addr
);
    logic [PAGE_W-1:0] low_nx;
    assign low_nx = addr[PAGE_W-1:0] + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         addr <= '0;
        else if (load)      addr <= load_val;
        else if (step_seq)  addr <= addr + 1'b1;
        else if (step_page) addr <= {addr[ADDR_W-1:PAGE_W], low_nx};
    end
endmodule

// File: rtl/eep_spi_front.sv
module eep_spi_front
    import eep_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int PAGE   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    input  logic              hold_n,
    output logic              so,
    output logic              so_oe,
    input  logic              busy,
    input  logic [5:0]        stat_hi,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] prot_addr,
    input  logic              prot_ok,
    input  logic              sr_ok,
    output logic              pg_load,
    output logic [ADDR_W-1:0] pg_addr,
    output logic [7:0]        pg_data,
    output logic              pg_commit,
    output logic              sr_wr,
    output logic [7:0]        sr_data
);
    localparam int PAGE_W     = $clog2(PAGE);
    localparam int ADDR_BYTES = (ADDR_W > 9) ? 2 : 1;
    localparam bit A8_IN_OP   = (ADDR_W == 9);

    // pin synchronisation and edge events
    logic sck_s, cs_s, hold_s, si_s;
    logic sck_d, cs_d;

    eep_pin_sync #(.N(4), .RST_VAL(4'b0110)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck, cs_n, hold_n, si}),
        .q     ({sck_s, cs_s, hold_s, si_s})
    );

    eep_state_t st, st_nx;
    logic [2:0] bit_cnt;
    logic [7:0] rx, rx_next, tx, addr_hi, sr_byte;
    logic       a8_q, addr_left, is_rd;
    logic       so_q, oe_q, wel, load_pend, loaded_any, paused;
    logic       pg_load_q, pg_commit_q, sr_wr_q;
    logic [ADDR_W-1:0] pg_addr_q, addr, addr_new;
    logic [16:0] addr_wide;
    eep_cmd_t   cmd;

    logic cs_rise_e, cs_fall_e, act, sck_r, sck_f, byte_done;
    assign cs_rise_e = cs_s & ~cs_d;
    assign cs_fall_e = ~cs_s & cs_d;
    assign act       = ~cs_s & ~paused & (st != ST_IDLE);
    assign sck_r     = act & sck_s & ~sck_d;
    assign sck_f     = act & ~sck_s & sck_d;
    assign rx_next   = {rx[6:0], si_s};
    assign byte_done = sck_r && (bit_cnt == 3'd7);

    eep_op_decode #(.A8_IN_OP(A8_IN_OP)) u_dec (
        .op  (rx_next),
        .cmd (cmd)
    );

    assign addr_wide = (ADDR_BYTES == 2) ? {1'b0, addr_hi, rx_next}
                                         : {8'h00, a8_q, rx_next};
    assign addr_new  = ADDR_W'(addr_wide);

    logic ctr_load, ctr_seq, ctr_page;
    assign ctr_load = byte_done && (st == ST_ADDR) && !addr_left;
    assign ctr_seq  = load_pend && (st == ST_RDDATA);
    assign ctr_page = byte_done && (st == ST_WRDATA);

    eep_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ctr_load),
        .load_val  (addr_new),
        .step_seq  (ctr_seq),
        .step_page (ctr_page),
        .addr      (addr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        if (cs_rise_e) begin
            st_nx = ST_IDLE;
        end else if (cs_fall_e) begin
            st_nx = ST_OPCODE;
        end else if (byte_done) begin
            unique case (st)
                ST_OPCODE: begin
                    if (busy && cmd != CMD_RDSR) begin
                        st_nx = ST_IGNORE;
                    end else begin
                        unique case (cmd)
                            CMD_WREN:  st_nx = ST_WRENWAIT;
                            CMD_WRDI:  st_nx = ST_DRAIN;
                            CMD_RDSR:  st_nx = ST_RDSTAT;
                            CMD_WRSR:  st_nx = ST_WRSTAT;
                            CMD_READ:  st_nx = ST_ADDR;
                            CMD_WRITE: st_nx = ST_ADDR;
                            CMD_NONE:  st_nx = ST_IGNORE;
                        endcase
                    end
                end
                ST_ADDR:   if (!addr_left) st_nx = is_rd ? ST_RDDATA : ST_WRDATA;
                ST_WRSTAT: st_nx = ST_STATHELD;
                default:   st_nx = st;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;  cs_d <= 1'b1;  paused <= 1'b0;
            bit_cnt <= '0;  rx <= '0;  tx <= '0;  addr_hi <= '0;  sr_byte <= '0;
            a8_q <= 1'b0;  addr_left <= 1'b0;  is_rd <= 1'b0;
            so_q <= 1'b0;  oe_q <= 1'b0;  wel <= 1'b0;
            load_pend <= 1'b0;  loaded_any <= 1'b0;
            pg_load_q <= 1'b0;  pg_commit_q <= 1'b0;  sr_wr_q <= 1'b0;
            pg_addr_q <= '0;  pg_data <= '0;  sr_data <= '0;
        end else begin
            pg_load_q   <= 1'b0;
            pg_commit_q <= 1'b0;
            sr_wr_q     <= 1'b0;
            load_pend   <= 1'b0;
            sck_d       <= sck_s;
            cs_d        <= cs_s;

            if (cs_s)        paused <= 1'b0;
            else if (!sck_s) paused <= ~hold_s;

            if (cs_rise_e) begin
                if (bit_cnt == 3'd0) begin
                    if (st == ST_WRENWAIT) wel <= 1'b1;
                    if (st == ST_WRDATA && loaded_any) begin
                        pg_commit_q <= 1'b1;
                        wel         <= 1'b0;
                    end
                    if (st == ST_STATHELD && wel && sr_ok) begin
                        sr_wr_q <= 1'b1;
                        sr_data <= sr_byte;
                        wel     <= 1'b0;
                    end
                end
                oe_q       <= 1'b0;
                bit_cnt    <= '0;
                loaded_any <= 1'b0;
            end else if (cs_fall_e) begin
                bit_cnt <= '0;
                oe_q    <= 1'b0;
            end else begin
                if (sck_r) begin
                    rx      <= rx_next;
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (byte_done) begin
                    case (st)
                        ST_OPCODE: begin
                            a8_q      <= rx_next[3];
                            addr_left <= 1'(ADDR_BYTES - 1);
                            is_rd     <= (cmd == CMD_READ);
                            if (!(busy && cmd != CMD_RDSR)) begin
                                if (cmd == CMD_WRDI) wel <= 1'b0;
                                if (cmd == CMD_RDSR) load_pend <= 1'b1;
                            end
                        end
                        ST_ADDR: begin
                            if (addr_left) begin
                                addr_hi   <= rx_next;
                                addr_left <= 1'b0;
                            end else if (is_rd) begin
                                load_pend <= 1'b1;
                            end
                        end
                        ST_RDDATA, ST_RDSTAT: load_pend <= 1'b1;
                        ST_WRDATA: begin
                            if (wel && prot_ok) begin
                                pg_load_q  <= 1'b1;
                                pg_addr_q  <= addr;
                                pg_data    <= rx_next;
                                loaded_any <= 1'b1;
                            end
                        end
                        ST_WRSTAT: sr_byte <= rx_next;
                        default: ;
                    endcase
                end
                if (load_pend)
                    tx <= (st == ST_RDSTAT) ? {stat_hi, wel, busy} : rd_data;
                if (sck_f && (st == ST_RDDATA || st == ST_RDSTAT)) begin
                    so_q <= tx[7];
                    tx   <= {tx[6:0], 1'b0};
                    oe_q <= 1'b1;
                end
            end
        end
    end

    assign so        = so_q;
    assign so_oe     = oe_q & ~paused;
    assign rd_addr   = addr;
    assign prot_addr = addr;
    assign pg_load   = pg_load_q;
    assign pg_addr   = pg_addr_q;
    assign pg_commit = pg_commit_q;
    assign sr_wr     = sr_wr_q;
endmodule

// File: rtl/eep_spi_front_chk.sv
module eep_spi_front_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic so_oe,
    input logic wel,
    input logic busy,
    input logic pg_load,
    input logic pg_commit,
    input logic sr_wr
);
    p_quiet_oe_r14: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) |-> !so_oe);

    p_load_needs_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pg_load |-> wel);

    p_commit_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pg_commit |=> !wel);

    p_single_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pg_load, pg_commit, sr_wr}));

    p_srwr_had_wel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr |-> $past(wel));

    p_wel_on_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> cs_n);

    p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !pg_commit && !sr_wr);
endmodule

bind eep_spi_front eep_spi_front_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .so_oe     (so_oe),
    .wel       (wel),
    .busy      (busy),
    .pg_load   (pg_load),
    .pg_commit (pg_commit),
    .sr_wr     (sr_wr)
);

// File: tb/eep_spi_front_tb_top.sv
`timescale 1ns/1ps
module eep_spi_front_tb_top;
    localparam int AW   = 9;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
    logic so, so_oe, busy = 1'b0, sr_ok = 1'b1, prot_ok;
    logic [5:0] stat_hi = 6'h2A;
    logic [AW-1:0] rd_addr, prot_addr, pg_addr;
    logic [7:0] rd_data, pg_data, sr_data;
    logic pg_load, pg_commit, sr_wr;

    always #10 clk = ~clk;

    logic [7:0] mem [512];
    assign rd_data = mem[rd_addr];
    assign prot_ok = (prot_addr < 9'h180);

    eep_spi_front #(.ADDR_W(AW), .PAGE(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
        .so(so), .so_oe(so_oe), .busy(busy), .stat_hi(stat_hi),
        .rd_addr(rd_addr), .rd_data(rd_data), .prot_addr(prot_addr), .prot_ok(prot_ok),
        .sr_ok(sr_ok), .pg_load(pg_load), .pg_addr(pg_addr), .pg_data(pg_data),
        .pg_commit(pg_commit), .sr_wr(sr_wr), .sr_data(sr_data)
    );

    int total = 0, bad = 0, commits = 0, quiet = 0;
    logic [16:0] ld_q [$];
    logic [7:0]  sr_q [$];
    bit mode3 = 1'b0, done = 1'b0;

    always @(posedge clk) begin
        if (pg_load)   ld_q.push_back({pg_addr, pg_data});
        if (pg_commit) commits++;
        if (sr_wr)     sr_q.push_back(sr_data);
    end

    // per-clock comparison: output released while select is high (R14)
    always @(negedge clk) begin
        if (cs_n) quiet++; else quiet = 0;
        if (rst_n && quiet > 6) begin
            total++;
            if (so_oe !== 1'b0) begin
                bad++;
                $display("FAIL R14 deselected drive act=%b exp=0", so_oe);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic xbit(input logic b, output logic o, output logic e);
        if (mode3) sck = 1'b0;
        si = b;
        repeat (HALF) @(negedge clk);
        o = so; e = so_oe;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        if (!mode3) sck = 1'b0;
    endtask

    task automatic xbyte(input logic [7:0] d, output logic [7:0] r,
                         output logic all_oe, output logic any_oe);
        all_oe = 1'b1; any_oe = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            logic o, e;
            xbit(d[i], o, e);
            r[i] = o;
            all_oe &= e;
            any_oe |= e;
        end
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_hi();
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d);
        logic [7:0] r; logic a, n;
        xbyte(d, r, a, n);
    endtask

    task automatic cmd1(input logic [7:0] op);
        cs_lo(); send(op); cs_hi();
    endtask

    task automatic rd_stat(output logic [7:0] s);
        logic a, n;
        cs_lo(); send(8'h05); xbyte(8'h00, s, a, n); cs_hi();
    endtask

    task automatic chk_load(input string tag, input int a, input int d);
        logic [16:0] v;
        if (ld_q.size() == 0) begin
            chk(tag, -1, {a[8:0], d[7:0]});
        end else begin
            v = ld_q.pop_front();
            chk(tag, int'(v), {a[8:0], d[7:0]});
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        summary();
    end

    initial begin
        logic [7:0] s, r;
        logic a, n;
        int c0;
        for (int i = 0; i < 512; i++) mem[i] = 8'((i * 7 + 3) ^ (i >> 3));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        chk("R1 oe after reset", so_oe, 0);
        rd_stat(s);
        chk("R1 R4 status after reset", s, {6'h2A, 1'b0, 1'b0});

        // R4 repeated status bytes
        cs_lo(); send(8'h05);
        xbyte(8'h00, r, a, n); chk("R4 status byte 1", r, 8'hA8);
        chk("R4 driven during status", a, 1);
        xbyte(8'h00, r, a, n); chk("R4 status repeats", r, 8'hA8);
        cs_hi();

        // R2 latch sets only on deselect; trailing bytes start nothing
        cs_lo(); send(8'h06); send(8'h02); send(8'h10); send(8'h55); cs_hi();
        chk("R2 no load after set-enable in same select", ld_q.size(), 0);
        rd_stat(s); chk("R2 latch set", s[1], 1);

        // R3 clear
        cmd1(8'h04);
        rd_stat(s); chk("R3 latch cleared", s[1], 0);

        // R5 read with A8 in opcode and wrap
        cs_lo(); send(8'h0B); xbyte(8'hFE, r, a, n);
        chk("R5 no drive during address", n, 0);
        xbyte(8'h00, r, a, n); chk("R5 byte 0x1FE", r, mem[9'h1FE]);
        chk("R5 driven during data", a, 1);
        xbyte(8'h00, r, a, n); chk("R5 byte 0x1FF", r, mem[9'h1FF]);
        xbyte(8'h00, r, a, n); chk("R5 wrap to 0", r, mem[0]);
        xbyte(8'h00, r, a, n); chk("R5 byte 1", r, mem[1]);
        cs_hi();
        cs_lo(); send(8'h03); send(8'h77);
        xbyte(8'h00, r, a, n); chk("R5 low half read", r, mem[9'h077]);
        cs_hi();

        // R6 R8 page write with wrap inside the page
        cmd1(8'h06);
        c0 = commits;
        cs_lo(); send(8'h0A); send(8'h1E); send(8'hA1); send(8'hB2); send(8'hC3); cs_hi();
        chk("R6 load count", ld_q.size(), 3);
        chk_load("R6 first load", 9'h11E, 8'hA1);
        chk_load("R6 page end", 9'h11F, 8'hB2);
        chk_load("R6 page wrap", 9'h110, 8'hC3);
        chk("R8 commit issued", commits - c0, 1);
        rd_stat(s); chk("R8 latch cleared after commit", s[1], 0);

        // R7 refused address
        cmd1(8'h06);
        c0 = commits;
        cs_lo(); send(8'h0A); send(8'h85); send(8'h11); send(8'h22); cs_hi();
        chk("R7 refused bytes not loaded", ld_q.size(), 0);
        chk("R7 no commit without load", commits - c0, 0);
        rd_stat(s); chk("R7 latch kept", s[1], 1);

        // R13 truncated write: loads but no commit, latch kept
        c0 = commits;
        cs_lo(); send(8'h02); send(8'h20); send(8'h5A);
        for (int i = 0; i < 4; i++) begin logic o, e; xbit(1'b1, o, e); end
        cs_hi();
        chk_load("R13 whole byte loaded", 9'h020, 8'h5A);
        chk("R13 no commit on partial", commits - c0, 0);
        rd_stat(s); chk("R13 latch unchanged by partial write", s[1], 1);
        cmd1(8'h04);
        cs_lo(); send(8'h06);
        for (int i = 0; i < 4; i++) begin logic o, e; xbit(1'b0, o, e); end
        cs_hi();
        rd_stat(s); chk("R13 partial set-enable ignored", s[1], 0);

        // R9 status write
        cmd1(8'h06);
        cs_lo(); send(8'h01); send(8'h8C); cs_hi();
        chk("R9 status write count", sr_q.size(), 1);
        if (sr_q.size() > 0) chk("R9 status data", sr_q.pop_front(), 8'h8C);
        rd_stat(s); chk("R9 latch cleared", s[1], 0);
        cmd1(8'h06);
        sr_ok = 1'b0;
        cs_lo(); send(8'h01); send(8'h04); cs_hi();
        chk("R9 refused status write", sr_q.size(), 0);
        rd_stat(s); chk("R9 latch kept when refused", s[1], 1);
        sr_ok = 1'b1;
        cmd1(8'h04);

        // R10 busy
        busy = 1'b1;
        repeat (4) @(negedge clk);
        cmd1(8'h06);
        rd_stat(s); chk("R10 R4 status while busy", s, {6'h2A, 1'b0, 1'b1});
        cs_lo(); send(8'h03); send(8'h10); xbyte(8'h00, r, a, n); cs_hi();
        chk("R10 read ignored while busy", n, 0);
        cs_lo(); send(8'h02); send(8'h10); send(8'h99); cs_hi();
        chk("R10 write ignored while busy", ld_q.size(), 0);
        busy = 1'b0;
        repeat (4) @(negedge clk);

        // R11 invalid opcode
        cs_lo(); send(8'hFF); xbyte(8'h00, r, a, n); chk("R11 undriven after bad opcode", n, 0);
        xbyte(8'h05, r, a, n); xbyte(8'h00, r, a, n); chk("R11 stays undriven", n, 0);
        cs_hi();
        rd_stat(s); chk("R11 next select works", s, 8'hA8);

        // R12 pause in the middle of a read byte
        cs_lo(); send(8'h03); send(8'h50);
        r = '0; a = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            logic o, e;
            if (i == 4) begin
                hold_n = 1'b0;
                repeat (HALF) @(negedge clk);
                chk("R12 released while paused", so_oe, 0);
                for (int k = 0; k < 3; k++) begin
                    si = k[0];
                    sck = 1'b1; repeat (HALF) @(negedge clk);
                    chk("R12 released during paused clocks", so_oe, 0);
                    sck = 1'b0; repeat (HALF) @(negedge clk);
                end
                hold_n = 1'b1;
                repeat (HALF) @(negedge clk);
            end
            xbit(1'b0, o, e);
            r[i] = o; a &= e;
        end
        chk("R12 byte resumed intact", r, mem[9'h050]);
        chk("R12 driven after resume", a, 1);
        xbyte(8'h00, r, a, n); chk("R12 next byte after pause", r, mem[9'h051]);
        cs_hi();

        // R14 mode 3
        mode3 = 1'b1; sck = 1'b1;
        repeat (2 * HALF) @(negedge clk);
        cs_lo(); send(8'h03); send(8'hC3);
        xbyte(8'h00, r, a, n); chk("R14 mode 3 read", r, mem[9'h0C3]);
        xbyte(8'h00, r, a, n); chk("R14 mode 3 sequential", r, mem[9'h0C4]);
        cs_hi();
        rd_stat(s); chk("R14 mode 3 status", s, 8'hA8);
        chk("R14 undriven when deselected", so_oe, 0);

        summary();
    end
endmodule